// File: doc/BRIEF.md
# Two-Level Lookahead Binary Adder

This block adds two unsigned operands and a carry-in in one combinational pass. It produces the sum and the carry-out. It is for datapaths where a full-width add must settle within one clock period, and where a long ripple chain would set the critical path. The operand is cut into equal slices, four bits each by default. Each slice is served by a lookahead block, and a second lookahead level joins the blocks.

Each bit cell forms a generate term (both operand bits set) and a propagate term (either operand bit set). Neither term depends on any carry. Each slice reduces its bit terms to one slice generate and one slice propagate.

A second-level unit takes those slice terms and the carry-in. From them it forms every carry at a slice boundary, all in parallel, as expanded sums of products. Each slice then forms its own internal carries from its bit terms and its incoming boundary carry, also as expanded sums of products. The sum bit is the exclusive-or of the two operand bits and the carry into that position. The default build is a 16-bit adder.

Top module: `cla_adder16`

## Requirements
- R1: `sum` equals the low 16 bits of the integer value x + y + c_in, for every combination of inputs.
- R2: `c_out` equals bit 16 of the integer value x + y + c_in. It is 1 exactly when the true result is 65536 or more.
- R3: When x XOR y is all ones (every position propagates and none generates), `sum` is the bitwise inverse of c_in replicated, and `c_out` equals c_in. The carry-in crosses all four slices.
- R4: With x = 0 and y = 0, `sum` equals c_in in bit 0 and zero elsewhere, and `c_out` is 0.
- R5: A carry produced inside one slice reaches the next slice. For example, 0x000F + 0x0001 gives 0x0010, 0x00FF + 0x0001 gives 0x0100, and 0x0FFF + 0x0001 gives 0x1000. A carry out of the top slice appears on `c_out`: 0x8000 + 0x8000 gives sum 0x0000 with `c_out` = 1.
- R6: A position where both operand bits are 1 produces a carry whatever its propagate term is. 0xFFFF + 0xFFFF + 1 gives sum 0xFFFF with `c_out` = 1.
- R7: The carry into each slice boundary (bit positions 4, 8 and 12) equals the carry out of adding only the bits below that boundary plus c_in.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| x | input | 16 | First addend |
| y | input | 16 | Second addend |
| c_in | input | 1 | Carry into bit 0 |
| sum | output | 16 | Low 16 bits of the result |
| c_out | output | 1 | Carry out of bit 15 |

## Verification
The bench builds the adder with its default parameters: a slice width of 4 and four slices. This puts every slice boundary, and the final carry-out, within reach of short directed vectors. Patterns where every position propagates push the carry-in through both lookahead levels. Patterns that generate just below a boundary exercise each boundary carry on its own. Random operands with random carry-in cover the mixed cases, against an integer model of the addition.

// File: rtl/cla_pkg.sv
package cla_pkg;

  localparam int DEF_BLK_W   = 4;
  localparam int DEF_NUM_BLK = 4;
  localparam int MAX_TERMS   = 64;

  typedef logic [MAX_TERMS-1:0] term_vec_t;

  // Carry into position j, as a fully expanded sum of products.
  function automatic logic sop_carry(input term_vec_t g, input term_vec_t p,
                                     input logic cin, input int j);
    logic acc;
    logic term;
    acc = 1'b0;
    for (int i = 0; i < j; i++) begin
      term = g[i];
      for (int k = i + 1; k < j; k++) term = term & p[k];
      acc = acc | term;
    end
    term = cin;
    for (int k = 0; k < j; k++) term = term & p[k];
    return acc | term;
  endfunction

  // Generate term of a group of n positions.
  function automatic logic group_gen(input term_vec_t g, input term_vec_t p, input int n);
    return sop_carry(g, p, 1'b0, n);
  endfunction

  // Propagate term of a group of n positions.
  function automatic logic group_prop(input term_vec_t p, input int n);
    logic acc;
    acc = 1'b1;
    for (int k = 0; k < n; k++) acc = acc & p[k];
    return acc;
  endfunction

endpackage

// File: rtl/cla_bit_cell.sv
module cla_bit_cell (
  input  logic xb,
  input  logic yb,
  output logic gen,
  output logic prop,
  output logic half
);
  assign gen  = xb & yb;
  assign prop = xb | yb;
  assign half = xb ^ yb;
endmodule

// File: rtl/cla_lookahead.sv
module cla_lookahead #(
  parameter int N = 4
) (
  input  logic [N-1:0] g,
  input  logic [N-1:0] p,
  input  logic         cin,
  output logic [N-1:0] c
);
  import cla_pkg::*;

  assign c[0] = cin;

  for (genvar j = 1; j < N; j++) begin : g_carry
    assign c[j] = sop_carry(term_vec_t'(g), term_vec_t'(p), cin, j);
  end
endmodule

// File: rtl/cla_block.sv
module cla_block #(
  parameter int BLK_W = 4
) (
  input  logic [BLK_W-1:0] x,
  input  logic [BLK_W-1:0] y,
  input  logic             cin,
  output logic [BLK_W-1:0] sum,
  output logic             blk_g,
  output logic             blk_p
);
  import cla_pkg::*;

  logic [BLK_W-1:0] bit_g;
  logic [BLK_W-1:0] bit_p;
  logic [BLK_W-1:0] bit_h;
  logic [BLK_W-1:0] bit_c;

  for (genvar i = 0; i < BLK_W; i++) begin : g_cell
    cla_bit_cell u_cell (
      .xb  (x[i]),
      .yb  (y[i]),
      .gen (bit_g[i]),
      .prop(bit_p[i]),
      .half(bit_h[i])
    );
  end

  cla_lookahead #(.N(BLK_W)) u_la (
    .g  (bit_g),
    .p  (bit_p),
    .cin(cin),
    .c  (bit_c)
  );

  assign blk_g = group_gen(term_vec_t'(bit_g), term_vec_t'(bit_p), BLK_W);
  assign blk_p = group_prop(term_vec_t'(bit_p), BLK_W);
  assign sum   = bit_h ^ bit_c;
endmodule

// File: rtl/cla_group_unit.sv
module cla_group_unit #(
  parameter int NUM_BLK = 4
) (
  input  logic [NUM_BLK-1:0] blk_g,
  input  logic [NUM_BLK-1:0] blk_p,
  input  logic               cin,
  output logic [NUM_BLK:0]   blk_cin
);
  import cla_pkg::*;

  assign blk_cin[0] = cin;

  for (genvar k = 1; k <= NUM_BLK; k++) begin : g_bcarry
    assign blk_cin[k] = sop_carry(term_vec_t'(blk_g), term_vec_t'(blk_p), cin, k);
  end
endmodule

// File: rtl/cla_adder16.sv
module cla_adder16 #(
  parameter int BLK_W   = cla_pkg::DEF_BLK_W,
  parameter int NUM_BLK = cla_pkg::DEF_NUM_BLK
) (
  input  logic [BLK_W*NUM_BLK-1:0] x,
  input  logic [BLK_W*NUM_BLK-1:0] y,
  input  logic                     c_in,
  output logic [BLK_W*NUM_BLK-1:0] sum,
  output logic                     c_out
);
  localparam int WIDTH = BLK_W * NUM_BLK;

  logic [NUM_BLK-1:0] blk_g;
  logic [NUM_BLK-1:0] blk_p;
  // Boundary carries: [0] is the carry-in, [NUM_BLK] the carry-out.
  logic [NUM_BLK:0]   blk_carry;

  for (genvar k = 0; k < NUM_BLK; k++) begin : g_blk
    cla_block #(.BLK_W(BLK_W)) u_blk (
      .x    (x[k*BLK_W +: BLK_W]),
      .y    (y[k*BLK_W +: BLK_W]),
      .cin  (blk_carry[k]),
      .sum  (sum[k*BLK_W +: BLK_W]),
      .blk_g(blk_g[k]),
      .blk_p(blk_p[k])
    );
  end

  cla_group_unit #(.NUM_BLK(NUM_BLK)) u_grp (
    .blk_g  (blk_g),
    .blk_p  (blk_p),
    .cin    (c_in),
    .blk_cin(blk_carry)
  );

  assign c_out = blk_carry[NUM_BLK];

  if (WIDTH > cla_pkg::MAX_TERMS * cla_pkg::MAX_TERMS) begin : g_bad_width
    initial $error("operand width out of supported range");
  end
endmodule

// File: rtl/cla_adder16_chk.sv
module cla_adder16_chk #(
  parameter int BLK_W   = 4,
  parameter int NUM_BLK = 4
) (
  input logic [BLK_W*NUM_BLK-1:0] x,
  input logic [BLK_W*NUM_BLK-1:0] y,
  input logic                     c_in,
  input logic [BLK_W*NUM_BLK-1:0] sum,
  input logic                     c_out,
  input logic [NUM_BLK:0]         blk_carry
);
  localparam int WIDTH = BLK_W * NUM_BLK;

  logic [WIDTH:0] full;
  assign full = {1'b0, x} + {1'b0, y} + {{WIDTH{1'b0}}, c_in};

  always_comb begin
    // R1
    sum_value_chk: assert (sum == full[WIDTH-1:0])
      else $error("sum mismatch");
    // R2
    carry_out_chk: assert (c_out == full[WIDTH])
      else $error("carry-out mismatch");
    // R3
    prop_chain_chk: assert (!((x ^ y) == {WIDTH{1'b1}}) || (c_out == c_in))
      else $error("propagate chain lost carry");
    // R4
    zero_operand_chk: assert (!(x == '0 && y == '0) ||
                              (sum == {{(WIDTH-1){1'b0}}, c_in} && !c_out))
      else $error("zero operand result wrong");
  end

  for (genvar k = 1; k < NUM_BLK; k++) begin : g_bnd
    localparam int LO = k * BLK_W;
    logic [LO:0] part;
    assign part = {1'b0, x[LO-1:0]} + {1'b0, y[LO-1:0]} + {{LO{1'b0}}, c_in};
    always_comb begin
      // R7
      blk_carry_chk: assert (blk_carry[k] == part[LO])
        else $error("boundary carry mismatch");
    end
  end
endmodule

bind cla_adder16 cla_adder16_chk #(.BLK_W(BLK_W), .NUM_BLK(NUM_BLK)) u_chk (
  .x        (x),
  .y        (y),
  .c_in     (c_in),
  .sum      (sum),
  .c_out    (c_out),
  .blk_carry(blk_carry)
);

// File: tb/test_cla_adder16.sv
module test_cla_adder16;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] x = '0;
  logic [W-1:0] y = '0;
  logic         c_in = 1'b0;
  logic [W-1:0] sum;
  logic         c_out;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  cla_adder16 i_cla_adder16 (
    .x    (x),
    .y    (y),
    .c_in (c_in),
    .sum  (sum),
    .c_out(c_out)
  );

  task automatic check_sum(input string rid, input logic [W-1:0] exp);
    n_chk++;
    if (sum !== exp) begin
      n_fail++;
      $display("FAIL %s sum x=%h y=%h c=%0d: actual %h expected %h", rid, x, y, c_in, sum, exp);
    end
  endtask

  task automatic check_cout(input string rid, input logic exp);
    n_chk++;
    if (c_out !== exp) begin
      n_fail++;
      $display("FAIL %s c_out x=%h y=%h c=%0d: actual %0d expected %0d", rid, x, y, c_in, c_out, exp);
    end
  endtask

  // Drive on the falling edge, sample one nanosecond after the next rising edge.
  task automatic apply(input logic [W-1:0] a, input logic [W-1:0] b, input logic ci);
    @(negedge clk);
    x = a;
    y = b;
    c_in = ci;
    @(posedge clk);
    #1;
  endtask

  // Reference: integer addition, done every cycle.
  task automatic run_ref(input string rid, input logic [W-1:0] a, input logic [W-1:0] b,
                         input logic ci);
    int unsigned total;
    apply(a, b, ci);
    total = int'(a) + int'(b) + int'(ci);
    check_sum(rid, total[W-1:0]);
    check_cout(rid, total[W]);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(posedge clk);
    #1;
    // R4: idle state after reset with zero inputs
    check_sum("R4", 16'h0000);
    check_cout("R4", 1'b0);
    run_ref("R4", 16'h0000, 16'h0000, 1'b1);
    check_sum("R4", 16'h0001);

    // R3: every position propagates
    run_ref("R3", 16'hAAAA, 16'h5555, 1'b1);
    check_sum("R3", 16'h0000);
    check_cout("R3", 1'b1);
    run_ref("R3", 16'h5555, 16'hAAAA, 1'b0);
    check_sum("R3", 16'hFFFF);
    check_cout("R3", 1'b0);
    run_ref("R3", 16'hFFFF, 16'h0000, 1'b1);
    run_ref("R3", 16'h0F0F, 16'hF0F0, 1'b1);

    // R5: carries across each slice boundary and out of the top
    run_ref("R5", 16'h000F, 16'h0001, 1'b0);
    check_sum("R5", 16'h0010);
    run_ref("R5", 16'h00FF, 16'h0001, 1'b0);
    check_sum("R5", 16'h0100);
    run_ref("R5", 16'h0FFF, 16'h0001, 1'b0);
    check_sum("R5", 16'h1000);
    run_ref("R5", 16'h8000, 16'h8000, 1'b0);
    check_cout("R5", 1'b1);

    // R7: boundary carry with and without carry-in reaching it
    run_ref("R7", 16'h0007, 16'h0008, 1'b1);
    check_sum("R7", 16'h0010);
    run_ref("R7", 16'h0080, 16'h0080, 1'b0);
    check_sum("R7", 16'h0100);
    run_ref("R7", 16'h0FF0, 16'h000F, 1'b1);
    check_sum("R7", 16'h1000);
    run_ref("R7", 16'h7777, 16'h8888, 1'b0);

    // R6: generate at every position
    run_ref("R6", 16'hFFFF, 16'hFFFF, 1'b1);
    check_sum("R6", 16'hFFFF);
    check_cout("R6", 1'b1);
    run_ref("R6", 16'hFFFF, 16'hFFFF, 1'b0);
    check_sum("R6", 16'hFFFE);

    // R1 and R2: random operands and carry-in
    for (int n = 0; n < 3000; n++) begin
      logic [W-1:0] a;
      logic [W-1:0] b;
      logic         ci;
      a = W'($urandom);
      b = W'($urandom);
      ci = 1'($urandom);
      run_ref("R1/R2", a, b, ci);
    end

    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #100000;
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule